// File: doc/BRIEF.md
# Dual Prescaled Down-Counting Timer

This block holds two 32-bit timer channels that run side by side on the system clock and do not affect each other. Each channel has an 8-bit prescaler, a reload value and a down counter. When the counter is asked to step below zero, it takes the reload value again. That event sets a sticky flag. Software can poll the flag, or it can be turned into an interrupt line.

A channel steps only while two things hold: its run bit is set, and its external enable input sits at the level chosen by a polarity bit. With polarity 0, a channel whose enable pin is tied low still counts. Software reaches all registers through a flat, single-cycle register bus. The bus has a write strobe and an address, and reads are combinational. Writing the reload value while a channel is stopped also loads the counter, so the first period after start-up is exact. The enable inputs are assumed to be synchronous to the system clock.

Top module: `dual_tick_timer`

## Requirements
- R1: Two channels are selected by address bit 2 (0 = channel A, 1 = channel B). Nothing written to or happening on one channel changes the other channel's registers, count or interrupt.
- R2: While a channel is active, its prescaler lets the counter step once every (prescale+1) clocks; a prescale of 0 steps every clock. The prescale phase returns to zero whenever the channel is inactive and in the cycle the prescale register is written. The step decision in a cycle uses the values held before any write in that cycle.
- R3: On a step, a nonzero count decreases by one. A count of zero instead takes the reload value, and that step is an overrun.
- R4: Within a channel, address bits [1:0] select: 0 = reload (read/write, 32 bits), 1 = count (read-only), 2 = prescale (read/write, bits [7:0], upper bits read 0), 3 = control/status.
- R5: Control/status bits: bit0 = run, bit1 = interrupt enable, bit2 = enable polarity, bit3 = overrun flag. Upper bits read 0. The flag is set by an overrun and cleared by writing 1 to bit3; an overrun in the same cycle wins.
- R6: irq[n] equals channel n's overrun flag ANDed with its interrupt-enable bit.
- R7: A channel is active only when run = 1 and extEn[n] equals the polarity bit. With polarity 0 and extEn low, the channel counts. With a mismatching level, the count holds.
- R8: Writing reload while run = 0 also sets the count to the written value. While run = 1, a reload write leaves the count on its normal path.
- R9: After reset, every register, count and flag reads 0, and both irq lines are 0.
- R10: Writes to the count address have no effect.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rstN | input | 1 | Active-low synchronous reset |
| wrEn | input | 1 | Register write strobe |
| addr | input | 3 | Register address: bit 2 channel, bits 1:0 register |
| wrData | input | 32 | Write data |
| extEn | input | 2 | External enable per channel, synchronous |
| rdData | output | 32 | Combinational read data for addr |
| irq | output | 2 | Per-channel interrupt |

## Verification
Three things are hard to bring about from the ports, and all of them meet at an overrun. The first is an overrun landing in the same cycle as a flag-clear write. The second is a reload write while running, arriving just as the count reaches zero. The third is a prescale write in the middle of a prescaler phase. Random stimulus keeps reload values below 24 and prescale values below 4, so overruns come every few dozen clocks. Writes land on about one cycle in five, spread over all eight addresses, and the enable levels and polarity bits are toggled at random. A directed prologue first walks channel A through a stopped reload, a start with a tied-low enable, a wrap, a flag clear, a blocked enable, and a prescale change in mid-run.

// File: rtl/dtt_pkg.sv
package dtt_pkg;
  localparam int unsigned DTT_N_CH  = 2;
  localparam int unsigned DTT_CNT_W = 32;
  localparam int unsigned DTT_PS_W  = 8;

  // Register select within a channel (address bits [1:0])
  localparam logic [1:0] REG_RELOAD   = 2'd0;
  localparam logic [1:0] REG_COUNT    = 2'd1;
  localparam logic [1:0] REG_PRESCALE = 2'd2;
  localparam logic [1:0] REG_CTRL     = 2'd3;

  // Control/status bit positions
  localparam int unsigned BIT_RUN  = 0;
  localparam int unsigned BIT_IE   = 1;
  localparam int unsigned BIT_POL  = 2;
  localparam int unsigned BIT_FLAG = 3;

  // Per-channel strobes from control to datapath
  typedef struct packed {
    logic tick;        // one counter step this cycle
    logic loadReload;  // capture wrData into reload
    logic loadCount;   // capture wrData into counter (stopped channel)
    logic clearFlag;   // write-one-to-clear of the overrun flag
  } dtt_strobe_t;
endpackage

// File: rtl/dtt_datapath.sv
module dtt_datapath
  import dtt_pkg::*;
#(
  parameter int unsigned CNT_W = DTT_CNT_W
) (
  input  logic              clk,
  input  logic              rstN,
  input  dtt_strobe_t       strobe,
  input  logic [CNT_W-1:0]  wrData,
  output logic [CNT_W-1:0]  countQ,
  output logic [CNT_W-1:0]  reloadQ,
  output logic              flagQ
);
  logic atZero;
  logic overrun;

  assign atZero  = (countQ == '0);
  assign overrun = strobe.tick & atZero;

  always_ff @(posedge clk) begin
    if (!rstN) begin
      reloadQ <= '0;
    end else if (strobe.loadReload) begin
      reloadQ <= wrData;
    end
  end

  always_ff @(posedge clk) begin
    if (!rstN) begin
      countQ <= '0;
    end else if (strobe.loadCount) begin
      countQ <= wrData;
    end else if (strobe.tick) begin
      countQ <= atZero ? reloadQ : (countQ - CNT_W'(1));
    end
  end

  always_ff @(posedge clk) begin
    if (!rstN) begin
      flagQ <= 1'b0;
    end else if (overrun) begin
      flagQ <= 1'b1;
    end else if (strobe.clearFlag) begin
      flagQ <= 1'b0;
    end
  end
endmodule

// File: rtl/dtt_ctrl.sv
module dtt_ctrl
  import dtt_pkg::*;
#(
  parameter int unsigned N_CH    = DTT_N_CH,
  parameter int unsigned CNT_W   = DTT_CNT_W,
  parameter int unsigned PS_W    = DTT_PS_W,
  parameter int unsigned CH_BITS = (N_CH > 1) ? $clog2(N_CH) : 1,
  parameter int unsigned ADDR_W  = CH_BITS + 2
) (
  input  logic                         clk,
  input  logic                         rstN,
  input  logic                         wrEn,
  input  logic [ADDR_W-1:0]            addr,
  input  logic [PS_W-1:0]              wrLow,
  input  logic [N_CH-1:0]              extEn,
  input  logic [N_CH-1:0][CNT_W-1:0]   countQ,
  input  logic [N_CH-1:0][CNT_W-1:0]   reloadQ,
  input  logic [N_CH-1:0]              flagQ,
  output dtt_strobe_t [N_CH-1:0]       strobe,
  output logic [CNT_W-1:0]             rdData,
  output logic [N_CH-1:0]              irq
);
  localparam int unsigned CTRL_PAD = CNT_W - 4;
  localparam int unsigned PS_PAD   = CNT_W - PS_W;

  logic [CH_BITS-1:0] chSel;
  logic [1:0]         regSel;
  logic [N_CH-1:0]    runQ, ieQ, polQ;
  logic [N_CH-1:0][PS_W-1:0] prescaleQ;
  logic [N_CH-1:0][PS_W-1:0] phaseQ;

  assign chSel  = addr[ADDR_W-1:2];
  assign regSel = addr[1:0];

  for (genvar ch = 0; ch < N_CH; ch++) begin : g_chan
    logic hit, wrReload, wrPrescale, wrCtrl, active, stepNow;

    assign hit        = wrEn && (chSel == CH_BITS'(ch));
    assign wrReload   = hit && (regSel == REG_RELOAD);
    assign wrPrescale = hit && (regSel == REG_PRESCALE);
    assign wrCtrl     = hit && (regSel == REG_CTRL);
    assign active     = runQ[ch] && (extEn[ch] == polQ[ch]);
    assign stepNow    = active && (phaseQ[ch] == prescaleQ[ch]);

    always_ff @(posedge clk) begin
      if (!rstN) begin
        runQ[ch] <= 1'b0;
        ieQ[ch]  <= 1'b0;
        polQ[ch] <= 1'b0;
      end else if (wrCtrl) begin
        runQ[ch] <= wrLow[BIT_RUN];
        ieQ[ch]  <= wrLow[BIT_IE];
        polQ[ch] <= wrLow[BIT_POL];
      end
    end

    always_ff @(posedge clk) begin
      if (!rstN) begin
        prescaleQ[ch] <= '0;
        phaseQ[ch]    <= '0;
      end else if (wrPrescale) begin
        prescaleQ[ch] <= wrLow;
        phaseQ[ch]    <= '0;
      end else if (!active || stepNow) begin
        phaseQ[ch]    <= '0;
      end else begin
        phaseQ[ch]    <= phaseQ[ch] + PS_W'(1);
      end
    end

    assign strobe[ch].tick       = stepNow;
    assign strobe[ch].loadReload = wrReload;
    assign strobe[ch].loadCount  = wrReload && !runQ[ch];
    assign strobe[ch].clearFlag  = wrCtrl && wrLow[BIT_FLAG];
    assign irq[ch]               = flagQ[ch] && ieQ[ch];
  end

  always_comb begin
    rdData = '0;
    for (int ch = 0; ch < N_CH; ch++) begin
      if (chSel == CH_BITS'(ch)) begin
        unique case (regSel)
          REG_RELOAD:   rdData = reloadQ[ch];
          REG_COUNT:    rdData = countQ[ch];
          REG_PRESCALE: rdData = {{PS_PAD{1'b0}}, prescaleQ[ch]};
          REG_CTRL:     rdData = {{CTRL_PAD{1'b0}}, flagQ[ch], polQ[ch],
                                  ieQ[ch], runQ[ch]};
          default:      rdData = '0;
        endcase
      end
    end
  end
endmodule

// File: rtl/dual_tick_timer.sv
module dual_tick_timer
  import dtt_pkg::*;
#(
  parameter int unsigned N_CH  = DTT_N_CH,
  parameter int unsigned CNT_W = DTT_CNT_W,
  parameter int unsigned PS_W  = DTT_PS_W,
  localparam int unsigned CH_BITS = (N_CH > 1) ? $clog2(N_CH) : 1,
  localparam int unsigned ADDR_W  = CH_BITS + 2
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic              wrEn,
  input  logic [ADDR_W-1:0] addr,
  input  logic [CNT_W-1:0]  wrData,
  input  logic [N_CH-1:0]   extEn,
  output logic [CNT_W-1:0]  rdData,
  output logic [N_CH-1:0]   irq
);
  dtt_strobe_t [N_CH-1:0]     strobe;
  logic [N_CH-1:0][CNT_W-1:0] countQ;
  logic [N_CH-1:0][CNT_W-1:0] reloadQ;
  logic [N_CH-1:0]            flagQ;

  dtt_ctrl #(
    .N_CH(N_CH), .CNT_W(CNT_W), .PS_W(PS_W),
    .CH_BITS(CH_BITS), .ADDR_W(ADDR_W)
  ) u_ctrl (
    .clk(clk), .rstN(rstN), .wrEn(wrEn), .addr(addr),
    .wrLow(wrData[PS_W-1:0]), .extEn(extEn),
    .countQ(countQ), .reloadQ(reloadQ), .flagQ(flagQ),
    .strobe(strobe), .rdData(rdData), .irq(irq)
  );

  for (genvar ch = 0; ch < N_CH; ch++) begin : g_dp
    dtt_datapath #(.CNT_W(CNT_W)) u_dp (
      .clk(clk), .rstN(rstN), .strobe(strobe[ch]), .wrData(wrData),
      .countQ(countQ[ch]), .reloadQ(reloadQ[ch]), .flagQ(flagQ[ch])
    );
  end
endmodule

// File: rtl/dtt_checker.sv
module dtt_checker
  import dtt_pkg::*;
#(
  parameter int unsigned N_CH  = DTT_N_CH,
  parameter int unsigned CNT_W = DTT_CNT_W
) (
  input logic                       clk,
  input logic                       rstN,
  input logic [CNT_W-1:0]           wrData,
  input dtt_strobe_t [N_CH-1:0]     strobe,
  input logic [N_CH-1:0][CNT_W-1:0] countQ,
  input logic [N_CH-1:0][CNT_W-1:0] reloadQ,
  input logic [N_CH-1:0]            flagQ,
  input logic [N_CH-1:0]            irq
);
  for (genvar i = 0; i < N_CH; i++) begin : g_chk
    assert_wrap_to_reload_R3: assert property (@(posedge clk) disable iff (!rstN)
      (strobe[i].tick && countQ[i] == '0) |=> (countQ[i] == $past(reloadQ[i])));

    assert_step_down_R3: assert property (@(posedge clk) disable iff (!rstN)
      (strobe[i].tick && countQ[i] != '0) |=> (countQ[i] == $past(countQ[i]) - CNT_W'(1)));

    assert_hold_when_idle_R7: assert property (@(posedge clk) disable iff (!rstN)
      (!strobe[i].tick && !strobe[i].loadCount) |=> $stable(countQ[i]));

    assert_stopped_load_R8: assert property (@(posedge clk) disable iff (!rstN)
      strobe[i].loadCount |=> (countQ[i] == $past(wrData)));

    assert_reload_capture_R4: assert property (@(posedge clk) disable iff (!rstN)
      strobe[i].loadReload |=> (reloadQ[i] == $past(wrData)));

    assert_flag_set_R5: assert property (@(posedge clk) disable iff (!rstN)
      (strobe[i].tick && countQ[i] == '0) |=> flagQ[i]);

    assert_flag_clear_R5: assert property (@(posedge clk) disable iff (!rstN)
      (strobe[i].clearFlag && !(strobe[i].tick && countQ[i] == '0)) |=> !flagQ[i]);

    assert_irq_needs_flag_R6: assert property (@(posedge clk) disable iff (!rstN)
      irq[i] |-> flagQ[i]);
  end
endmodule

bind dual_tick_timer dtt_checker #(.N_CH(N_CH), .CNT_W(CNT_W)) u_chk (
  .clk(clk), .rstN(rstN), .wrData(wrData), .strobe(strobe),
  .countQ(countQ), .reloadQ(reloadQ), .flagQ(flagQ), .irq(irq)
);

// File: tb/dual_tick_timer_test.sv
module dual_tick_timer_test;
  logic        clk = 1'b0;
  logic        rstN = 1'b0;
  logic        wrEn = 1'b0;
  logic [2:0]  addr = '0;
  logic [31:0] wrData = '0;
  logic [1:0]  extEn = '0;
  logic [31:0] rdData;
  logic [1:0]  irq;

  int checks = 0;
  int fails = 0;
  bit done = 1'b0;

  // reference state
  logic [31:0] mCnt[2], mRel[2];
  logic [7:0]  mPre[2], mPh[2];
  logic        mRun[2], mIe[2], mPol[2], mFlag[2];

  always #5 clk = ~clk;

  dual_tick_timer uut (
    .clk(clk), .rstN(rstN), .wrEn(wrEn), .addr(addr), .wrData(wrData),
    .extEn(extEn), .rdData(rdData), .irq(irq)
  );

  function automatic logic [31:0] modelRead(input logic [2:0] a);
    int c = int'(a[2]);
    case (a[1:0])
      2'd0:    return mRel[c];
      2'd1:    return mCnt[c];
      2'd2:    return {24'd0, mPre[c]};
      default: return {28'd0, mFlag[c], mPol[c], mIe[c], mRun[c]};
    endcase
  endfunction

  function automatic string tagFor(input logic [2:0] a);
    case (a[1:0])
      2'd0:    return "R4";
      2'd1:    return "R3";
      2'd2:    return "R2";
      default: return "R5";
    endcase
  endfunction

  task automatic check(input logic [31:0] act, input logic [31:0] exp, input string tag,
                       input string what);
    checks++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s %s actual=%0h expected=%0h", tag, what, act, exp);
    end
  endtask

  task automatic modelReset();
    for (int c = 0; c < 2; c++) begin
      mCnt[c] = '0; mRel[c] = '0; mPre[c] = '0; mPh[c] = '0;
      mRun[c] = 0; mIe[c] = 0; mPol[c] = 0; mFlag[c] = 0;
    end
  endtask

  // advance the reference by one clock using pre-edge state
  task automatic modelStep(input logic we, input logic [2:0] a, input logic [31:0] d,
                           input logic [1:0] ext);
    for (int c = 0; c < 2; c++) begin
      logic sel = we && (int'(a[2]) == c);
      logic act = mRun[c] && (ext[c] == mPol[c]);
      logic tk  = act && (mPh[c] == mPre[c]);
      logic ov  = tk && (mCnt[c] == 0);
      if (sel && a[1:0] == 2'd0 && !mRun[c]) mCnt[c] = d;
      else if (tk) mCnt[c] = (mCnt[c] == 0) ? mRel[c] : mCnt[c] - 1;
      if (sel && a[1:0] == 2'd0) mRel[c] = d;
      if (sel && a[1:0] == 2'd2) begin mPre[c] = d[7:0]; mPh[c] = '0; end
      else if (!act || tk) mPh[c] = '0;
      else mPh[c] = mPh[c] + 1;
      if (ov) mFlag[c] = 1;
      else if (sel && a[1:0] == 2'd3 && d[3]) mFlag[c] = 0;
      if (sel && a[1:0] == 2'd3) begin mRun[c] = d[0]; mIe[c] = d[1]; mPol[c] = d[2]; end
    end
  endtask

  // starts and ends at a falling edge
  task automatic cycle(input logic we, input logic [2:0] a, input logic [31:0] d);
    wrEn = we; addr = a; wrData = d;
    #1;
    check(rdData, modelRead(a), tagFor(a), "read vs model");
    check({30'd0, irq}, {30'd0, mFlag[1] & mIe[1], mFlag[0] & mIe[0]}, "R6", "irq vs model");
    @(posedge clk);
    modelStep(we, a, d, extEn);
    @(negedge clk);
    wrEn = 1'b0;
  endtask

  task automatic idle(input int n);
    for (int i = 0; i < n; i++) cycle(1'b0, 3'd1, 32'd0);
  endtask

  task automatic expectReg(input logic [2:0] a, input logic [31:0] exp, input string tag);
    addr = a;
    #1;
    check(rdData, exp, tag, "directed read");
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    if (!done) begin
      fails++;
      checks++;
      $display("FAIL watchdog R1 actual=hung expected=finished");
      $display("*** SUMMARY: %0d compared / %0d mismatched ***", checks, fails);
      $finish;
    end
  end

  initial begin
    int seedSink;
    seedSink = $urandom(32'h5EED_2024);
    modelReset();
    repeat (3) @(negedge clk);
    rstN = 1'b1;

    // R9: reset values
    for (int a = 0; a < 8; a++) expectReg(3'(a), 32'd0, "R9");
    check({30'd0, irq}, 32'd0, "R9", "irq after reset");

    // R8: reload write while stopped loads the count
    cycle(1'b1, 3'd0, 32'd5);
    expectReg(3'd1, 32'd5, "R8");
    // R7: run, irq enable, polarity 0 with extEn low
    extEn = 2'b00;
    cycle(1'b1, 3'd3, 32'h3);
    idle(3);
    expectReg(3'd1, 32'd2, "R7");
    expectReg(3'd5, 32'd0, "R1");
    // R8: reload write while running does not touch count
    cycle(1'b1, 3'd0, 32'd9);
    expectReg(3'd1, 32'd1, "R8");
    expectReg(3'd0, 32'd9, "R4");
    idle(2);
    expectReg(3'd1, 32'd9, "R3");
    expectReg(3'd3, 32'hB, "R5");
    check({30'd0, irq}, 32'd1, "R6", "irq after overrun");
    // R10: count address is read-only
    cycle(1'b1, 3'd1, 32'd100);
    expectReg(3'd1, 32'd8, "R10");
    // R5: write-one-to-clear
    cycle(1'b1, 3'd3, 32'hB);
    expectReg(3'd3, 32'h3, "R5");
    check({30'd0, irq}, 32'd0, "R6", "irq after clear");
    // R7: mismatching enable level holds the count
    extEn = 2'b01;
    idle(3);
    expectReg(3'd1, 32'd7, "R7");
    extEn = 2'b00;
    // R2: prescale 2 written mid-run
    cycle(1'b1, 3'd2, 32'd2);
    idle(2);
    expectReg(3'd1, 32'd6, "R2");
    idle(1);
    expectReg(3'd1, 32'd5, "R2");
    expectReg(3'd5, 32'd0, "R1");

    // constrained random phase
    for (int n = 0; n < 6000; n++) begin
      logic we = ($urandom % 5) == 0;
      logic [2:0] a = 3'($urandom % 8);
      logic [31:0] d;
      case (a[1:0])
        2'd0:    d = $urandom % 24;
        2'd1:    d = $urandom;
        2'd2:    d = $urandom % 4;
        default: d = {28'd0, 1'($urandom % 2), 1'($urandom % 2), 1'($urandom % 2),
                      1'(($urandom % 4) != 0)};
      endcase
      if (($urandom % 16) == 0) extEn = 2'($urandom % 4);
      cycle(we, a, d);
    end

    done = 1'b1;
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", checks, fails);
    $finish;
  end
endmodule